// File: doc/BRIEF.md
# Static Wear-Leveling Erase Tracker

This block watches the stream of block erases issued by a flash controller and decides when blocks holding cold data must be recycled, so that erase wear spreads across the whole device. Physical blocks are gathered into groups of 2^GROUP_SHIFT neighbours. Each group owns one flag, which records whether any block of that group has been erased in the current tracking interval. Two counters run next to the flags: the number of raised flags and the number of erases reported since the interval began.

When the erase count reaches THRESHOLD times the flag count, the erase traffic is concentrated on too few groups. A circular pointer then walks the flag array, one group per cycle, until it meets a group with no flag. The block issues a valid/ready request carrying the first block number of that group. The surrounding firmware or garbage collector moves the live data out of that group and erases it. That erase comes back through the notify port, which raises the group's flag. When every flag is raised, the interval ends and the tracker starts over from an empty state.

Top module: `swl_erase_tracker`

## Requirements
- R1: After a synchronous active-low reset, reqValid is low, all flags are clear, both counters are zero and the scan pointer is at group 0.
- R2: An erase of block b belongs to group b >> GROUP_SHIFT, so blocks that differ only in their low GROUP_SHIFT bits share one flag.
- R3: An erase in a group whose flag is clear raises the flag and increments both the flag count and the erase count. An erase in a group whose flag is already raised increments only the erase count.
- R4: While no request is pending or being searched, the search starts on the clock after the flag count is nonzero and the erase count is at least THRESHOLD times the flag count.
- R5: The search examines one group per cycle, starting at the pointer and wrapping from the last group to group 0. It selects the first group whose flag is clear, and reqBlock is that group's number shifted left by GROUP_SHIFT, so its low GROUP_SHIFT bits are zero.
- R6: After a selection the pointer rests on the group following the selected one. The next search resumes there and not at group 0.
- R7: Once reqValid is high, it stays high with reqBlock unchanged until a cycle with reqReady high. reqValid is low in the cycle after that handshake.
- R8: Erases reported while a request is pending or a search is running update the flags and counters as in R3.
- R9: An erase that raises the last clear flag clears all flags and sets both counters to zero. Leveling then stays idle until the ratio of R4 is met again within the new interval.
- R10: The erase counter saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| eraseValid | input | 1 | One block erase is reported this cycle |
| eraseBlock | input | log2(NUM_BLOCKS) | Physical number of the erased block |
| reqValid | output | 1 | A recycle request is pending |
| reqReady | input | 1 | The consumer takes the pending request |
| reqBlock | output | log2(NUM_BLOCKS) | First block of the group chosen for recycling |

## Verification
The bench targets repeat erases inside a flagged group. A design that counted these as new flags would hold back the trigger indefinitely. It targets erases that arrive while a request waits. Dropping them would raise a spurious second request, because the ratio would look too high. It forces a search to wrap past the end of the array and checks that a second search resumes after the previous pick. A pointer that reset to zero, or failed to wrap, would name the wrong group. It also fills the last clear flag, where a missed interval clear leaves the old erase count behind and fires early. Finally, it pushes more erases than the counter can hold, where a wrapping counter would silence leveling.

// File: rtl/swl_pkg.sv
package swl_pkg;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic stepPtr;   // move the scan pointer one group on
    logic capture;   // latch the group under the pointer as the request
  } swl_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2
  } swl_state_t;

endpackage

// File: rtl/swl_track_dp.sv
module swl_track_dp
  import swl_pkg::*;
#(
  parameter int NUM_BLOCKS  = 64,
  parameter int GROUP_SHIFT = 2,
  parameter int THRESHOLD   = 100,
  parameter int ECNT_W      = 16,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int NGROUPS = NUM_BLOCKS >> GROUP_SHIFT,
  localparam int GRP_W   = $clog2(NGROUPS),
  localparam int FCNT_W  = $clog2(NGROUPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eraseValid,
  input  logic [BLK_W-1:0]   eraseBlock,
  input  swl_ctrl_t          ctrl,
  output logic               trigger,
  output logic               flagAtPtr,
  output logic [BLK_W-1:0]   reqBlock,
  output logic [NGROUPS-1:0] flagBits,
  output logic [FCNT_W-1:0]  fcnt
);

  localparam int THR_W = $clog2(THRESHOLD + 1);
  localparam int CMP_W = THR_W + FCNT_W + ECNT_W;

  logic [ECNT_W-1:0] ecnt;
  logic [GRP_W-1:0]  scanPtr;
  logic [GRP_W-1:0]  eraseGrp;
  logic              groupHit;
  logic              groupNew;
  logic              fillAll;
  logic [CMP_W-1:0]  needed;

  assign eraseGrp = GRP_W'(eraseBlock >> GROUP_SHIFT);
  assign groupHit = eraseValid && flagBits[eraseGrp];
  assign groupNew = eraseValid && !flagBits[eraseGrp];
  assign fillAll  = groupNew && (fcnt == FCNT_W'(NGROUPS - 1));

  // erase flags and the two interval counters
  always_ff @(posedge clk) begin
    if (!rst_n || fillAll) begin
      flagBits <= '0;
      fcnt     <= '0;
      ecnt     <= '0;
    end else if (eraseValid) begin
      if (ecnt != {ECNT_W{1'b1}}) ecnt <= ecnt + 1'b1;
      if (groupNew) begin
        flagBits[eraseGrp] <= 1'b1;
        fcnt               <= fcnt + 1'b1;
      end
    end
  end

  // ratio trigger: ecnt >= THRESHOLD * fcnt with a nonzero fcnt
  assign needed  = CMP_W'(THRESHOLD) * CMP_W'(fcnt);
  assign trigger = (fcnt != '0) && (CMP_W'(ecnt) >= needed);

  // circular scan pointer and request register
  assign flagAtPtr = flagBits[scanPtr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanPtr  <= '0;
      reqBlock <= '0;
    end else begin
      if (ctrl.capture) reqBlock <= BLK_W'(scanPtr) << GROUP_SHIFT;
      if (ctrl.stepPtr)
        scanPtr <= (scanPtr == GRP_W'(NGROUPS - 1)) ? '0 : scanPtr + 1'b1;
    end
  end

  // groupHit is kept for readability of the update rule above
  logic unusedHit;
  assign unusedHit = groupHit;

endmodule

// File: rtl/swl_track_ctrl.sv
module swl_track_ctrl
  import swl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trigger,
  input  logic      flagAtPtr,
  input  logic      reqReady,
  output swl_ctrl_t ctrl,
  output logic      reqValid
);

  swl_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    ctrl.stepPtr = 1'b0;
    ctrl.capture = 1'b0;
    case (state)
      ST_IDLE: if (trigger) stateNext = ST_SCAN;
      ST_SCAN: begin
        ctrl.stepPtr = 1'b1;
        if (!flagAtPtr) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_REQ;
        end
      end
      ST_REQ:  if (reqReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqValid = (state == ST_REQ);

endmodule

// File: rtl/swl_erase_tracker.sv
module swl_erase_tracker
  import swl_pkg::*;
#(
  parameter int NUM_BLOCKS  = 64,
  parameter int GROUP_SHIFT = 2,
  parameter int THRESHOLD   = 100,
  parameter int ECNT_W      = 16,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int NGROUPS = NUM_BLOCKS >> GROUP_SHIFT,
  localparam int FCNT_W  = $clog2(NGROUPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eraseValid,
  input  logic [BLK_W-1:0] eraseBlock,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [BLK_W-1:0] reqBlock
);

  swl_ctrl_t          ctrl;
  logic               trigger;
  logic               flagAtPtr;
  logic [NGROUPS-1:0] flagBits;
  logic [FCNT_W-1:0]  fcnt;

  swl_track_dp #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .GROUP_SHIFT(GROUP_SHIFT),
    .THRESHOLD  (THRESHOLD),
    .ECNT_W     (ECNT_W)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .eraseValid(eraseValid),
    .eraseBlock(eraseBlock),
    .ctrl      (ctrl),
    .trigger   (trigger),
    .flagAtPtr (flagAtPtr),
    .reqBlock  (reqBlock),
    .flagBits  (flagBits),
    .fcnt      (fcnt)
  );

  swl_track_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger  (trigger),
    .flagAtPtr(flagAtPtr),
    .reqReady (reqReady),
    .ctrl     (ctrl),
    .reqValid (reqValid)
  );

endmodule

// File: rtl/swl_erase_tracker_chk.sv
module swl_erase_tracker_chk #(
  parameter int NUM_BLOCKS  = 64,
  parameter int GROUP_SHIFT = 2,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int NGROUPS = NUM_BLOCKS >> GROUP_SHIFT,
  localparam int FCNT_W  = $clog2(NGROUPS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eraseValid,
  input logic [BLK_W-1:0]   eraseBlock,
  input logic               reqValid,
  input logic               reqReady,
  input logic [BLK_W-1:0]   reqBlock,
  input logic [NGROUPS-1:0] flagBits,
  input logic [FCNT_W-1:0]  fcnt
);

  localparam logic [BLK_W-1:0] LOW_MASK = BLK_W'((1 << GROUP_SHIFT) - 1);

  logic [BLK_W-1:0] grpIdx;
  assign grpIdx = eraseBlock >> GROUP_SHIFT;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqBlock)); // R7

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqValid); // R7

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqBlock & LOW_MASK) == '0); // R5

  AST_FCNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fcnt) == $countones(flagBits)); // R3

  AST_REPEAT_NO_FCNT: assert property (@(posedge clk) disable iff (!rst_n)
    eraseValid && flagBits[grpIdx] |=> fcnt == $past(fcnt)); // R3

  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fcnt) < NGROUPS); // R9

  AST_INTERVAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eraseValid && !flagBits[grpIdx] && 32'(fcnt) == NGROUPS - 1
      |=> flagBits == '0); // R9

endmodule

bind swl_erase_tracker swl_erase_tracker_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .GROUP_SHIFT(GROUP_SHIFT)
) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eraseValid(eraseValid),
  .eraseBlock(eraseBlock),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqBlock  (reqBlock),
  .flagBits  (flagBits),
  .fcnt      (fcnt)
);

// File: tb/swl_erase_tracker_test.sv
module swl_erase_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 32;
  localparam int GS   = 2;
  localparam int THR  = 3;
  localparam int EW   = 8;
  localparam int NG   = NB >> GS;
  localparam int EMAX = (1 << EW) - 1;
  localparam int BW   = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eraseValid = 1'b0;
  logic [BW-1:0] eraseBlock = '0;
  logic reqReady = 1'b0;
  logic reqValid;
  logic [BW-1:0] reqBlock;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  swl_erase_tracker #(
    .NUM_BLOCKS(NB), .GROUP_SHIFT(GS), .THRESHOLD(THR), .ECNT_W(EW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .eraseValid(eraseValid), .eraseBlock(eraseBlock),
    .reqValid(reqValid), .reqReady(reqReady), .reqBlock(reqBlock)
  );

  // behavioural reference model
  bit mFlag[NG];
  int mEcnt, mFcnt, mPtr, mState, mBlk;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mFlag[i]) mFlag[i] = 1'b0;
      mEcnt = 0; mFcnt = 0; mPtr = 0; mState = 0; mBlk = 0;
    end else begin
      bit trig;
      int g;
      trig = (mFcnt != 0) && (mEcnt >= THR * mFcnt);
      case (mState)
        0: if (trig) mState = 1;
        1: begin
          if (!mFlag[mPtr]) begin
            mBlk = mPtr << GS;
            mState = 2;
          end
          mPtr = (mPtr + 1) % NG;
        end
        default: if (reqReady) mState = 0;
      endcase
      if (eraseValid) begin
        g = int'(eraseBlock) >> GS;
        if (mEcnt < EMAX) mEcnt++;
        if (!mFlag[g]) begin
          mFlag[g] = 1'b1;
          mFcnt++;
          if (mFcnt == NG) begin
            foreach (mFlag[i]) mFlag[i] = 1'b0;
            mFcnt = 0;
            mEcnt = 0;
          end
        end
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (reqValid !== (mState == 2) || ((mState == 2) && int'(reqBlock) != mBlk)) begin
        errors++;
        $display("FAIL %s: reqValid/reqBlock actual %0b/%0d expected %0b/%0d",
                 tag, reqValid, reqBlock, (mState == 2), mBlk);
      end
    end
  end

  task automatic doErase(input int b);
    eraseValid = 1'b1;
    eraseBlock = BW'(b);
    @(posedge clk); #1;
    eraseValid = 1'b0;
  endtask

  task automatic expectReq(input int blk, input bit accept, input bit anyBlk, input string t);
    bit found = 1'b0;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge clk);
      if (reqValid) found = 1'b1;
      @(posedge clk); #1;
    end
    checks++;
    if (!found) begin
      errors++;
      $display("FAIL %s: reqValid actual 0 expected 1", t);
    end else if (!anyBlk && int'(reqBlock) != blk) begin
      errors++;
      $display("FAIL %s: reqBlock actual %0d expected %0d", t, reqBlock, blk);
    end
    if (accept) begin
      reqReady = 1'b1;
      @(posedge clk); #1;
      reqReady = 1'b0;
    end
  endtask

  task automatic expectQuiet(input int n, input string t);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reqValid) seen = 1'b1;
      @(posedge clk); #1;
    end
    checks++;
    if (seen) begin
      errors++;
      $display("FAIL %s: reqValid actual 1 expected 0", t);
    end
  endtask

  task automatic expectHold(input int n, input string t);
    logic [BW-1:0] first;
    bit bad = 1'b0;
    @(negedge clk);
    first = reqBlock;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!reqValid || reqBlock != first) bad = 1'b1;
    end
    @(posedge clk); #1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: request hold actual valid=%0b block=%0d expected valid=1 block=%0d",
               t, reqValid, reqBlock, first);
    end
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (reqValid !== 1'b0) begin  // R1
      errors++;
      $display("FAIL R1: reqValid actual %0b expected 0", reqValid);
    end
    @(posedge clk); #1;

    // R2 / R3: blocks 5 and 6 share group 1; repeats do not add flags
    tag = "R3";
    doErase(5);
    doErase(6);
    expectQuiet(5, "R3");
    tag = "R4";
    doErase(6);                       // ecnt 3, fcnt 1 -> trigger
    expectReq(0, 1'b0, 1'b0, "R4");   // search from group 0
    tag = "R7";
    expectHold(4, "R7");
    tag = "R8";
    doErase(9);                       // group 2 while pending: fcnt 2 ecnt 4
    reqReady = 1'b1; @(posedge clk); #1; reqReady = 1'b0;
    expectQuiet(10, "R8");
    tag = "R6";
    doErase(9);
    doErase(9);                       // ecnt 6 -> trigger, resume at group 1
    expectReq(12, 1'b1, 1'b0, "R6");
    expectReq(16, 1'b1, 1'b0, "R6");
    tag = "R5";
    expectReq(20, 1'b0, 1'b0, "R5");
    doErase(0); doErase(16); doErase(20); doErase(24); doErase(28);
    for (int i = 0; i < 10; i++) doErase(0);   // ecnt 21, fcnt 7
    reqReady = 1'b1; @(posedge clk); #1; reqReady = 1'b0;
    expectReq(12, 1'b0, 1'b0, "R5");  // wrap past group 7 to group 3
    tag = "R9";
    doErase(12);                      // last clear flag -> new interval
    reqReady = 1'b1; @(posedge clk); #1; reqReady = 1'b0;
    expectQuiet(12, "R9");
    doErase(4);
    expectQuiet(8, "R9");
    doErase(4);
    doErase(4);
    expectReq(16, 1'b1, 1'b0, "R9");

    // R10: erase counter saturates instead of wrapping
    tag = "R10";
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    reqReady = 1'b1;
    eraseValid = 1'b1;
    eraseBlock = '0;
    repeat (EMAX + 2) @(posedge clk);
    #1 eraseValid = 1'b0;
    repeat (10) @(posedge clk);
    #1 reqReady = 1'b0;
    expectReq(0, 1'b1, 1'b1, "R10");

    repeat (3) @(posedge clk);
    finish();
  end

endmodule